// File: doc/BRIEF.md
# Dual-bank vectored interrupt prioritizer

This block takes 64 level-sensitive interrupt requests, arranged as two banks of 32, and reduces them to one registered vector word plus an interrupt line. Software reads the vector word to learn which source to service next. Each bank has a per-source enable mask and four programmable vectored slots. Each slot holds an enable bit and a 5-bit source select within its bank. Sources that sit in an enabled slot take precedence over all other sources. The remaining sources are scanned bank by bank.

The vector word is tagged with flags. Bit 8 marks a vectored winner and carries the 6-bit global source number in bits 5:0. This keeps source 0 distinct from "nothing pending". Bit 9 or bit 10 alone marks a non-vectored winner in the first or second bank. A register port with a synchronous write and a combinational read sets up the masks and slots and exposes raw status, masked status and the vector word.

Top module: `dual_vic_prio`

## Requirements
- R1: Global source n, for n in 0..63, is request bit n. Bank 0 owns bits 31:0 and bank 1 owns bits 63:32. The masked status equals the request AND the bank mask, where mask bit 1 means enabled. It appears on `masked_o` and in the masked status register. The raw status register returns the bank's request bits.
- R2: An active source that is unmasked and selected by an enabled slot always wins over any source that has no such slot.
- R3: Among vectored candidates, every bank 0 slot ranks above every bank 1 slot. Within a bank, the lower slot number wins, whatever the source numbers are.
- R4: Among non-vectored candidates, any active unmasked bank 0 source ranks above all bank 1 sources.
- R5: A vectored winner gives the vector 0x100 | (bank*32 + slot select). Source 0 therefore reads 0x100.
- R6: A non-vectored winner gives exactly 0x200 for bank 0 or exactly 0x400 for bank 1. Bits 7:0 are zero in both cases.
- R7: When no source is both active and unmasked, the vector is 0x000 and `irq_o` is low. This includes the case where every request is high but every mask bit is clear.
- R8: A slot whose enable is clear never wins. A slot whose selected source is masked off never wins. An active, unmasked source whose slot is disabled is treated as non-vectored.
- R9: The vector and `irq_o` are registered. Both reflect the requests, masks and slots in force at the previous rising edge, so a register write shows up one edge after the write edge. `irq_o` is high exactly when the vector is nonzero. Reset clears both to zero.
- R10: The vector register at offset 3 returns the same word in either bank.
- R11: Address bit 3 selects the bank. Bits 2:0 select the register: 0 is the mask (read/write), 1 is raw status, 2 is masked status, 3 is the vector, and 4..7 are slots 0..3 (read/write). A slot word holds the enable in bit 5 and the select in bits 4:0, and its upper bits read zero. Reset clears all masks and slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 64 | Level interrupt requests, global source numbering |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address: bank in bit 3, register in bits 2:0 |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address, same layout as the write address |
| rd_data_o | output | 32 | Combinational read data |
| masked_o | output | 64 | Request AND mask for all sources |
| vec_o | output | 11 | Registered vector word |
| irq_o | output | 1 | Registered, high when the vector is nonzero |

## Verification
A fixed slot and mask setup is driven with a table of request patterns, and each pattern isolates one ranking decision. Some patterns pit one bank's vectored slot against the other bank's unvectored source. Others put two slots of one bank, with inverted source numbers, against each other, or pair a vectored source on bank 0 with one on bank 1. The rest show a disabled slot, a slot pointing at a masked source, and source 0 alone. Directed steps separate the registered timing from a combinational path by sampling before and after the edge that follows a request change or a slot write. They also show that the vector reads the same word from both banks, and that a fully masked but fully requesting input produces no interrupt.

// File: rtl/dvic_pkg.sv
package dvic_pkg;

    localparam int N_BANKS      = 2;
    localparam int SRC_PER_BANK = 32;
    localparam int SLOTS        = 4;
    localparam int DATA_W       = 32;
    localparam int REG_W        = 3;
    localparam int VEC_W        = 11;

    localparam int SRC_W        = $clog2(SRC_PER_BANK);
    localparam int BANK_W       = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
    localparam int N_SRC        = N_BANKS * SRC_PER_BANK;
    localparam int NUM_W        = $clog2(N_SRC);
    localparam int ADDR_W       = BANK_W + REG_W;
    localparam int VEC_FLAG_BIT = 8;
    localparam int NONVEC_BIT0  = 9;

    localparam logic [REG_W-1:0] RG_MASK   = 3'd0;
    localparam logic [REG_W-1:0] RG_RAW    = 3'd1;
    localparam logic [REG_W-1:0] RG_MASKED = 3'd2;
    localparam logic [REG_W-1:0] RG_VEC    = 3'd3;
    localparam int               RG_SLOT0  = 4;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] sel;
    } slot_cfg_t;

    localparam int SLOT_CFG_W = $bits(slot_cfg_t);

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } slot_hit_t;

    function automatic logic [VEC_W-1:0] code_vectored(input int unsigned bank,
                                                        input logic [SRC_W-1:0] src);
        logic [VEC_W-1:0] c;
        c = '0;
        c[VEC_FLAG_BIT] = 1'b1;
        c[NUM_W-1:0] = NUM_W'(bank * SRC_PER_BANK) + NUM_W'(src);
        return c;
    endfunction

    function automatic logic [VEC_W-1:0] code_plain(input int unsigned bank);
        logic [VEC_W-1:0] c;
        c = '0;
        c[NONVEC_BIT0 + bank] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/dvic_bank.sv
module dvic_bank
    import dvic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [REG_W-1:0]             wr_reg,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [SRC_PER_BANK-1:0]      req,
    output logic [SRC_PER_BANK-1:0]      mask_o,
    output logic [SRC_PER_BANK-1:0]      masked_o,
    output slot_cfg_t [SLOTS-1:0]        cfg_o,
    output slot_hit_t                    hit_o,
    output logic                         any_o
);

    logic [SRC_PER_BANK-1:0] mask_q;
    slot_cfg_t [SLOTS-1:0]   cfg_q;

    // Mask and slot storage, written through the register port.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            if (wr_reg == RG_MASK) begin
                mask_q <= wr_data[SRC_PER_BANK-1:0];
            end
            for (int s = 0; s < SLOTS; s++) begin
                if (wr_reg == REG_W'(RG_SLOT0 + s)) begin
                    cfg_q[s] <= slot_cfg_t'(wr_data[SLOT_CFG_W-1:0]);
                end
            end
        end
    end

    assign masked_o = req & mask_q;
    assign mask_o   = mask_q;
    assign cfg_o    = cfg_q;
    assign any_o    = |masked_o;

    // Slot scan: walk from the highest slot down so the lowest live slot wins.
    always_comb begin
        hit_o = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (cfg_q[s].en && masked_o[cfg_q[s].sel]) begin
                hit_o.valid = 1'b1;
                hit_o.src   = cfg_q[s].sel;
            end
        end
    end

endmodule

// File: rtl/dvic_resolve.sv
module dvic_resolve
    import dvic_pkg::*;
(
    input  slot_hit_t          hit_i [N_BANKS],
    input  logic [N_BANKS-1:0] any_i,
    output logic [VEC_W-1:0]   vec_next
);

    logic found;

    // Global order: vectored hits bank by bank, then plain sources bank by bank.
    always_comb begin
        vec_next = '0;
        found    = 1'b0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (!found && hit_i[b].valid) begin
                vec_next = code_vectored(b, hit_i[b].src);
                found    = 1'b1;
            end
        end
        for (int b = 0; b < N_BANKS; b++) begin
            if (!found && any_i[b]) begin
                vec_next = code_plain(b);
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_vic_prio.sv
module dual_vic_prio
    import dvic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [63:0]          req_i,
    input  logic                 wr_en_i,
    input  logic [3:0]           wr_addr_i,
    input  logic [31:0]          wr_data_i,
    input  logic [3:0]           rd_addr_i,
    output logic [31:0]          rd_data_o,
    output logic [63:0]          masked_o,
    output logic [10:0]          vec_o,
    output logic                 irq_o
);

    logic [SRC_PER_BANK-1:0] mask_w [N_BANKS];
    logic [SRC_PER_BANK-1:0] mskd_w [N_BANKS];
    slot_cfg_t [SLOTS-1:0]   cfg_w  [N_BANKS];
    slot_hit_t               hit_w  [N_BANKS];
    logic [N_BANKS-1:0]      any_w;
    logic [VEC_W-1:0]        vec_next;
    logic [VEC_W-1:0]        vec_q;
    logic                    irq_q;

    logic [BANK_W-1:0] wr_bank, rd_bank;
    logic [REG_W-1:0]  wr_reg,  rd_reg;

    assign wr_bank = wr_addr_i[ADDR_W-1 -: BANK_W];
    assign wr_reg  = wr_addr_i[REG_W-1:0];
    assign rd_bank = rd_addr_i[ADDR_W-1 -: BANK_W];
    assign rd_reg  = rd_addr_i[REG_W-1:0];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        dvic_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en_i && (wr_bank == BANK_W'(b))),
            .wr_reg   (wr_reg),
            .wr_data  (wr_data_i),
            .req      (req_i[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .mask_o   (mask_w[b]),
            .masked_o (mskd_w[b]),
            .cfg_o    (cfg_w[b]),
            .hit_o    (hit_w[b]),
            .any_o    (any_w[b])
        );
        assign masked_o[b*SRC_PER_BANK +: SRC_PER_BANK] = mskd_w[b];
    end

    dvic_resolve u_resolve (
        .hit_i    (hit_w),
        .any_i    (any_w),
        .vec_next (vec_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            irq_q <= 1'b0;
        end else begin
            vec_q <= vec_next;
            irq_q <= |vec_next;
        end
    end

    assign vec_o = vec_q;
    assign irq_o = irq_q;

    // Register read; the vector word is common to every bank.
    always_comb begin
        rd_data_o = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (rd_bank == BANK_W'(b)) begin
                case (rd_reg)
                    RG_MASK:   rd_data_o = DATA_W'(mask_w[b]);
                    RG_RAW:    rd_data_o = DATA_W'(req_i[b*SRC_PER_BANK +: SRC_PER_BANK]);
                    RG_MASKED: rd_data_o = DATA_W'(mskd_w[b]);
                    RG_VEC:    rd_data_o = DATA_W'(vec_q);
                    default: begin
                        for (int s = 0; s < SLOTS; s++) begin
                            if (rd_reg == REG_W'(RG_SLOT0 + s)) begin
                                rd_data_o = DATA_W'(cfg_w[b][s]);
                            end
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/dvic_checker.sv
module dvic_checker
    import dvic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [N_SRC-1:0]  masked_i,
    input logic [VEC_W-1:0]  vec_i,
    input logic              irq_i
);

    logic [N_SRC-1:0] masked_d;

    always_ff @(posedge clk) begin
        if (rst) masked_d <= '0;
        else     masked_d <= masked_i;
    end

    // R9: the line and the word agree.
    p_irq_tracks_vec_r9: assert property (@(posedge clk) disable iff (rst)
        irq_i == (vec_i != '0));

    // R6: at most one tag flag is set.
    p_one_tag_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vec_i[NONVEC_BIT0+N_BANKS-1:VEC_FLAG_BIT]));

    // R6: plain codes carry zero low bits.
    p_plain_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_i[NONVEC_BIT0+N_BANKS-1:NONVEC_BIT0] != '0) |-> (vec_i[VEC_FLAG_BIT-1:0] == '0));

    // R7: nothing live gives a zero vector next cycle.
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (masked_i == '0) |=> (vec_i == '0));

    // R2: anything live gives a nonzero vector next cycle.
    p_live_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        (masked_i != '0) |=> (vec_i != '0));

    // R4: a live bank 0 source keeps the bank 1 plain code away.
    p_bank0_first_r4: assert property (@(posedge clk) disable iff (rst)
        (masked_i[SRC_PER_BANK-1:0] != '0) |=> (vec_i != code_plain(1)));

    // R5: a vectored code names a source that was live at the previous edge.
    p_vec_src_live_r5: assert property (@(posedge clk) disable iff (rst)
        vec_i[VEC_FLAG_BIT] |-> masked_d[vec_i[NUM_W-1:0]]);

endmodule

bind dual_vic_prio dvic_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .masked_i (masked_o),
    .vec_i    (vec_o),
    .irq_i    (irq_o)
);

// File: tb/sim_dual_vic_prio.sv
module sim_dual_vic_prio;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] req_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic [63:0] masked_o;
    logic [10:0] vec_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_vic_prio u0 (
        .clk(clk), .rst(rst), .req_i(req_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .masked_o(masked_o), .vec_o(vec_o), .irq_o(irq_o)
    );

    localparam logic [63:0] MASK_ALL = 64'hFFFF_FBFF_FFFF_FDFF;
    localparam int NT = 15;
    localparam logic [63:0] T_REQ [NT] = '{
        64'h0000_0000_0000_0000, // nothing
        64'h0000_0000_0000_0002, // src1 plain
        64'h0000_0100_0000_0000, // src40 plain bank1
        64'h0000_0100_0000_0002, // plain bank0 over plain bank1
        64'h0100_0000_0000_0002, // bank1 vectored over bank0 plain
        64'h0100_0000_0000_0020, // bank0 slot over bank1 slot
        64'h0000_0000_0000_0001, // source 0 vectored
        64'h0000_0000_0000_0021, // slot0 (src5) over slot1 (src0)
        64'h0000_0000_0000_0080, // src7 in disabled slot
        64'h0000_0000_0000_0200, // src9 masked, slot points at it
        64'h0000_0400_0000_0000, // src42 masked
        64'h0000_0108_0000_0000, // src35 vectored over src40 plain
        64'h8000_0400_0000_0200, // only src63 live
        64'h0000_0008_0000_0003, // bank0 slot1 over bank1 slot1
        64'h8100_0008_0000_0000  // bank1 slot0 over slot1
    };
    localparam logic [10:0] T_VEC [NT] = '{
        11'h000, 11'h200, 11'h400, 11'h200, 11'h138,
        11'h105, 11'h100, 11'h105, 11'h200, 11'h000,
        11'h000, 11'h123, 11'h400, 11'h100, 11'h138
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset vec", 64'(vec_o), 64'h0);
        chk("R9 reset irq", 64'(irq_o), 64'h0);
        rd(4'h0, d); chk("R11 reset mask", 64'(d), 64'h0);
        rd(4'hC, d); chk("R11 reset slot", 64'(d), 64'h0);
        rst = 1'b0;

        wr(4'h0, 32'hFFFF_FDFF);
        wr(4'h8, 32'hFFFF_FBFF);
        wr(4'h4, 32'h25); wr(4'h5, 32'h20); wr(4'h6, 32'h07); wr(4'h7, 32'h29);
        wr(4'hC, 32'h38); wr(4'hD, 32'h23); wr(4'hE, 32'h00); wr(4'hF, 32'h0A);
        rd(4'h4, d); chk("R11 slot readback", 64'(d), 64'h25);
        rd(4'hD, d); chk("R11 slot readback b1", 64'(d), 64'h23);
        rd(4'h8, d); chk("R11 mask readback", 64'(d), 64'hFFFF_FBFF);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R1
        for (int i = 0; i < NT; i++) begin
            @(negedge clk);
            req_i = T_REQ[i];
            step();
            chk($sformatf("R2-8 table %0d vec", i), 64'(vec_o), 64'(T_VEC[i]));
            chk($sformatf("R9 table %0d irq", i), 64'(irq_o), 64'(T_VEC[i] != 11'h0));
            chk($sformatf("R1 table %0d masked", i), masked_o, T_REQ[i] & MASK_ALL);
        end

        // R9: no change before the edge
        req_i = 64'h2;
        #2;
        chk("R9 before edge", 64'(vec_o), 64'h138);
        step();
        chk("R9 after edge", 64'(vec_o), 64'h200);

        // R10 and R1 register reads
        req_i = 64'h0100_0000_0000_0002;
        step();
        rd(4'h3, d); rd(4'hB, d2);
        chk("R10 vec bank0", 64'(d), 64'h138);
        chk("R10 vec bank1", 64'(d2), 64'h138);
        rd(4'h9, d); chk("R1 raw bank1", 64'(d), 64'h0100_0000);
        rd(4'h2, d); chk("R1 masked bank0", 64'(d), 64'h2);
        req_i = 64'h0000_0000_0000_0200;
        #1;
        rd(4'h1, d); chk("R1 raw bank0 masked src", 64'(d), 64'h200);
        rd(4'h2, d); chk("R1 masked bank0 masked src", 64'(d), 64'h0);

        // R8/R9: disabling a slot takes effect one edge after the write edge
        req_i = 64'h20;
        step();
        chk("R5 src5 vectored", 64'(vec_o), 64'h105);
        wr(4'h4, 32'h05);
        chk("R9 slot write old value", 64'(vec_o), 64'h105);
        step();
        chk("R8 disabled slot plain", 64'(vec_o), 64'h200);

        // R7: everything requested, everything masked
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h0);
        req_i = '1;
        step();
        chk("R7 all masked vec", 64'(vec_o), 64'h0);
        chk("R7 all masked irq", 64'(irq_o), 64'h0);
        chk("R7 all masked status", masked_o, 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule